// File: doc/BRIEF.md
# PCI Initiator Termination Controller

This block is the termination logic of a PCI bus master. When the initiator launches a transaction it drives FRAME# for the address phase and then IRDY# for the data phases. While it does so, it watches the target's DEVSEL#, TRDY# and STOP# lines. It then decides how the transaction ends. The possible endings are a normal completion of every requested data phase, a target-initiated end (disconnect with data, disconnect without data, retry or target abort), or a master abort when no target claims the cycle within the decode window.

An aborted or terminated transaction is always released in two steps. FRAME# goes high first, and IRDY# follows one clock later. The block reports the outcome as a code together with a one-cycle completion pulse. It counts the data words that completed and records the clock in which the target claimed the cycle. It keeps sticky flags for received master abort and received target abort, and each flag clears only by a write-one-to-clear strobe or by reset. A separate single-cycle pulse marks each master-abort event.

Clock edges are numbered from the address phase. Edge 1 is the rising edge that samples FRAME# low with IRDY# high. Edges 2, 3, 4 and 5 are the fast, medium, slow and subtractive claim slots.

Top module: `pci_term_ctl`

## Requirements
- R1: After reset, frame_n_o and irdy_n_o are high, done_o, busy_o, mabort_pulse_o and both sticky flags are low, and outcome_o is 0.
- R2: A start_i sampled while idle begins a transaction. FRAME# is low and IRDY# is high after that edge, and IRDY# is low after edge 1. A start_i sampled while busy_o is high is ignored and does not change the running transaction.
- R3: DEVSEL# sampled low at any of edges 2 through ABORT_CLK-1 (2 to 5 by default) claims the cycle. claim_slot_o then holds the number of the claiming edge.
- R4: If DEVSEL# is not sampled low by edge ABORT_CLK-1, FRAME# is high after that edge (if it was still low), and IRDY# is high after the next edge, which is the sixth clock.
- R5: A master abort gives outcome code 5, sets mabort_sts_o and pulses mabort_pulse_o high for exactly one cycle, in the cycle FRAME# is released. No data words are counted.
- R6: mabort_sts_o stays set until sts_clr_i[0] is sampled high, and tabort_sts_o stays set until sts_clr_i[1] is sampled high. Each strobe bit clears only its own flag.
- R7: Each edge that samples DEVSEL# and TRDY# low with STOP# high completes one word. FRAME# is high during the final data phase. After the last word, IRDY# rises and the outcome is code 0.
- R8: STOP#, TRDY# and DEVSEL# all sampled low is a disconnect with data. The word counts, and the outcome is code 1.
- R9: STOP# low with TRDY# high and DEVSEL# low counts no word. The outcome is code 3 (retry) if no word has completed yet in the transaction, and code 2 (disconnect without data) otherwise.
- R10: STOP# low with DEVSEL# high after the cycle was claimed is a target abort. It counts no word, gives outcome code 4 and sets tabort_sts_o.
- R11: On a target-initiated end, FRAME# goes high after the terminating edge if it was still low, and IRDY# goes high one edge later. If FRAME# was already high, IRDY# goes high after the terminating edge. IRDY# never rises while FRAME# is low.
- R12: done_o is high for exactly one cycle, in the cycle that IRDY# is released at the end of a transaction. In that cycle FRAME# and IRDY# are both high and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transaction (honoured when idle) |
| len_i | input | LEN_W | Number of data words requested (0 treated as 1) |
| devsel_n_i | input | 1 | Target DEVSEL#, active low |
| trdy_n_i | input | 1 | Target TRDY#, active low |
| stop_n_i | input | 1 | Target STOP#, active low |
| sts_clr_i | input | 2 | Write-one-to-clear: bit 0 master abort flag, bit 1 target abort flag |
| frame_n_o | output | 1 | Initiator FRAME#, active low |
| irdy_n_o | output | 1 | Initiator IRDY#, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| outcome_o | output | 3 | 0 normal, 1 disconnect with data, 2 disconnect without data, 3 retry, 4 target abort, 5 master abort |
| words_o | output | LEN_W | Words completed in the current or last transaction |
| claim_slot_o | output | CNT_W | Edge number at which DEVSEL# claimed the cycle |
| mabort_sts_o | output | 1 | Sticky received-master-abort flag |
| tabort_sts_o | output | 1 | Sticky received-target-abort flag |
| mabort_pulse_o | output | 1 | One-cycle pulse per master abort |

## Verification
The assertions check the following on every cycle:
- IRDY# is never released ahead of FRAME#.
- A master abort fires exactly ABORT_CLK-1 edges after the address phase, with FRAME# already high, and IRDY# and the completion pulse follow on the next edge.
- The completion pulse lasts one cycle with the bus idle.
- The sticky flags hold until their strobe.
- Every claimed transaction reports a slot inside the decode window.

Only the directed scenarios can show the classification of each STOP#/TRDY#/DEVSEL# combination, the word counts, and the exact release edges. They also cover the acceptance of each claim slot, including the subtractive one right before the abort point, and the independence of the two clear strobes.

// File: rtl/pti_pkg.sv
package pti_pkg;

    typedef enum logic [2:0] {
        OUT_NORMAL      = 3'd0,
        OUT_DISC_DATA   = 3'd1,
        OUT_DISC_NODATA = 3'd2,
        OUT_RETRY       = 3'd3,
        OUT_TABORT      = 3'd4,
        OUT_MABORT      = 3'd5
    } pti_outcome_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_DATA    = 2'd2,
        ST_RELEASE = 2'd3
    } pti_state_e;

    // Result of evaluating one data-phase edge.
    typedef struct packed {
        logic         xfer;   // a data word completes on this edge
        logic         term;   // the transaction ends on this edge
        pti_outcome_e code;   // outcome if term is set
    } pti_event_t;

    // STOP# without TRDY#: retry if nothing moved yet, else disconnect.
    function automatic pti_outcome_e stop_nodata_code(input logic words_zero);
        return words_zero ? OUT_RETRY : OUT_DISC_NODATA;
    endfunction

endpackage

// File: rtl/pti_decode_timer.sv
module pti_decode_timer #(
    parameter int ABORT_CLK = 6,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             addr_i,
    input  logic             window_i,
    input  logic             devsel_n_i,
    output logic             claim_o,
    output logic             timeout_o,
    output logic             claimed_o,
    output logic [CNT_W-1:0] slot_o
);
    localparam logic [CNT_W-1:0] LAST_EDGE  = CNT_W'(ABORT_CLK - 1);
    localparam logic [CNT_W-1:0] FIRST_SLOT = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;
    logic             claimed_q;
    logic [CNT_W-1:0] slot_q;

    // cnt_q holds the number of the edge about to be sampled.
    assign claim_o   = window_i & ~devsel_n_i & (cnt_q >= FIRST_SLOT);
    assign timeout_o = window_i &  devsel_n_i & (cnt_q == LAST_EDGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            claimed_q <= 1'b0;
            slot_q    <= '0;
        end else if (load_i) begin
            cnt_q     <= CNT_W'(1);
            claimed_q <= 1'b0;
            slot_q    <= '0;
        end else if (addr_i) begin
            cnt_q <= FIRST_SLOT;
        end else if (claim_o) begin
            claimed_q <= 1'b1;
            slot_q    <= cnt_q;
        end else if (window_i && cnt_q != LAST_EDGE) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign claimed_o = claimed_q;
    assign slot_o    = slot_q;
endmodule

// File: rtl/pti_term_classify.sv
module pti_term_classify
    import pti_pkg::*;
(
    input  logic       data_i,
    input  logic       claimed_i,
    input  logic       claim_i,
    input  logic       devsel_n_i,
    input  logic       trdy_n_i,
    input  logic       stop_n_i,
    input  logic       words_zero_i,
    input  logic       last_i,
    output pti_event_t ev_o
);
    logic engaged;
    assign engaged = data_i & (claimed_i | claim_i);

    always_comb begin
        ev_o = '{xfer: 1'b0, term: 1'b0, code: OUT_NORMAL};
        if (engaged) begin
            if (!stop_n_i) begin
                if (!devsel_n_i) begin
                    ev_o.term = 1'b1;
                    if (!trdy_n_i) begin
                        ev_o.xfer = 1'b1;
                        ev_o.code = OUT_DISC_DATA;
                    end else begin
                        ev_o.code = stop_nodata_code(words_zero_i);
                    end
                end else if (claimed_i) begin
                    ev_o.term = 1'b1;
                    ev_o.code = OUT_TABORT;
                end
            end else if (!trdy_n_i && !devsel_n_i) begin
                ev_o.xfer = 1'b1;
                ev_o.term = last_i;
                ev_o.code = OUT_NORMAL;
            end
        end
    end
endmodule

// File: rtl/pti_bus_seq.sv
module pti_bus_seq
    import pti_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  pti_event_t       ev_i,
    input  logic             timeout_i,
    output pti_state_e       state_o,
    output logic             load_o,
    output logic             frame_n_o,
    output logic             irdy_n_o,
    output logic             done_o,
    output pti_outcome_e     outcome_o,
    output logic [LEN_W-1:0] words_o,
    output logic             last_o,
    output logic             words_zero_o
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [LEN_W-1:0] TWO = LEN_W'(2);

    pti_state_e       state_q;
    logic             frame_n_q, irdy_n_q, done_q;
    pti_outcome_e     outcome_q;
    logic [LEN_W-1:0] words_q, rem_q;

    assign load_o       = start_i & (state_q == ST_IDLE);
    assign last_o       = (rem_q == ONE);
    assign words_zero_o = (words_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            frame_n_q <= 1'b1;
            irdy_n_q  <= 1'b1;
            done_q    <= 1'b0;
            outcome_q <= OUT_NORMAL;
            words_q   <= '0;
            rem_q     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        rem_q     <= (len_i == '0) ? ONE : len_i;
                        words_q   <= '0;
                        outcome_q <= OUT_NORMAL;
                        frame_n_q <= 1'b0;
                        irdy_n_q  <= 1'b1;
                        state_q   <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    irdy_n_q  <= 1'b0;
                    frame_n_q <= (rem_q == ONE);
                    state_q   <= ST_DATA;
                end
                ST_DATA: begin
                    if (timeout_i) begin
                        frame_n_q <= 1'b1;
                        outcome_q <= OUT_MABORT;
                        state_q   <= ST_RELEASE;
                    end else if (ev_i.term) begin
                        outcome_q <= ev_i.code;
                        if (ev_i.xfer) words_q <= words_q + ONE;
                        if (!frame_n_q) begin
                            frame_n_q <= 1'b1;
                            state_q   <= ST_RELEASE;
                        end else begin
                            irdy_n_q <= 1'b1;
                            done_q   <= 1'b1;
                            state_q  <= ST_IDLE;
                        end
                    end else if (ev_i.xfer) begin
                        words_q   <= words_q + ONE;
                        rem_q     <= rem_q - ONE;
                        frame_n_q <= (rem_q == TWO);
                    end
                end
                ST_RELEASE: begin
                    irdy_n_q <= 1'b1;
                    done_q   <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state_o   = state_q;
    assign frame_n_o = frame_n_q;
    assign irdy_n_o  = irdy_n_q;
    assign done_o    = done_q;
    assign outcome_o = outcome_q;
    assign words_o   = words_q;
endmodule

// File: rtl/pti_status.sv
module pti_status (
    input  logic       clk,
    input  logic       rst,
    input  logic       mabort_set_i,
    input  logic       tabort_set_i,
    input  logic [1:0] clr_i,
    output logic       mabort_sts_o,
    output logic       tabort_sts_o,
    output logic       mabort_pulse_o
);
    logic ma_q, ta_q, pulse_q;

    // A new event wins over a clear strobe in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ma_q    <= 1'b0;
            ta_q    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            ma_q    <= (ma_q & ~clr_i[0]) | mabort_set_i;
            ta_q    <= (ta_q & ~clr_i[1]) | tabort_set_i;
            pulse_q <= mabort_set_i;
        end
    end

    assign mabort_sts_o   = ma_q;
    assign tabort_sts_o   = ta_q;
    assign mabort_pulse_o = pulse_q;
endmodule

// File: rtl/pci_term_ctl.sv
module pci_term_ctl
    import pti_pkg::*;
#(
    parameter int LEN_W     = 8,
    parameter int ABORT_CLK = 6,
    parameter int CNT_W     = $clog2(ABORT_CLK + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             devsel_n_i,
    input  logic             trdy_n_i,
    input  logic             stop_n_i,
    input  logic [1:0]       sts_clr_i,
    output logic             frame_n_o,
    output logic             irdy_n_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [2:0]       outcome_o,
    output logic [LEN_W-1:0] words_o,
    output logic [CNT_W-1:0] claim_slot_o,
    output logic             mabort_sts_o,
    output logic             tabort_sts_o,
    output logic             mabort_pulse_o
);
    pti_state_e   state;
    pti_event_t   ev;
    pti_outcome_e outcome;
    logic load, claim, timeout, claimed, last, words_zero;
    logic in_data, in_addr, window;

    assign in_data = (state == ST_DATA);
    assign in_addr = (state == ST_ADDR);
    assign window  = in_data & ~claimed;

    pti_decode_timer #(.ABORT_CLK(ABORT_CLK), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load_i(load), .addr_i(in_addr),
        .window_i(window), .devsel_n_i(devsel_n_i),
        .claim_o(claim), .timeout_o(timeout), .claimed_o(claimed),
        .slot_o(claim_slot_o)
    );

    pti_term_classify u_class (
        .data_i(in_data), .claimed_i(claimed), .claim_i(claim),
        .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .words_zero_i(words_zero), .last_i(last), .ev_o(ev)
    );

    pti_bus_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .ev_i(ev), .timeout_i(timeout), .state_o(state), .load_o(load),
        .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o), .done_o(done_o),
        .outcome_o(outcome), .words_o(words_o), .last_o(last),
        .words_zero_o(words_zero)
    );

    pti_status u_sts (
        .clk(clk), .rst(rst), .mabort_set_i(timeout),
        .tabort_set_i(ev.term && ev.code == OUT_TABORT),
        .clr_i(sts_clr_i), .mabort_sts_o(mabort_sts_o),
        .tabort_sts_o(tabort_sts_o), .mabort_pulse_o(mabort_pulse_o)
    );

    assign busy_o    = (state != ST_IDLE);
    assign outcome_o = outcome;
endmodule

// File: rtl/pti_term_checker.sv
module pti_term_checker #(
    parameter int ABORT_CLK = 6,
    parameter int CNT_W     = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_n,
    input logic             irdy_n,
    input logic             busy,
    input logic             done,
    input logic [2:0]       outcome,
    input logic [CNT_W-1:0] slot,
    input logic             ma_pulse,
    input logic             ma_sts,
    input logic             ta_sts,
    input logic [1:0]       clr
);
    localparam int WIN_W = $clog2(ABORT_CLK + 1);

    logic             act_q;
    logic [WIN_W-1:0] win_q;

    // Counts edges since the address phase of the current transaction.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            win_q <= '0;
        end else if (!act_q && !frame_n && irdy_n) begin
            act_q <= 1'b1;
            win_q <= WIN_W'(1);
        end else if (act_q) begin
            if (done) act_q <= 1'b0;
            else if (win_q < WIN_W'(ABORT_CLK)) win_q <= win_q + WIN_W'(1);
        end
    end

    AST_IRDY_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(irdy_n) |-> frame_n);                                   // R11
    AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_n && irdy_n && !busy));                       // R12
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                              // R12
    AST_MABORT_FRAME_FIRST: assert property (@(posedge clk) disable iff (rst)
        ma_pulse |-> (frame_n && !irdy_n));                           // R4
    AST_MABORT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        ma_pulse |-> (win_q == WIN_W'(ABORT_CLK - 1)));               // R4
    AST_MABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ma_pulse |=> (irdy_n && done && outcome == 3'd5));            // R5
    AST_MABORT_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        ma_pulse |-> ma_sts);                                         // R5
    AST_MABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ma_sts && !clr[0]) |=> ma_sts);                              // R6
    AST_TABORT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ta_sts && !clr[1]) |=> ta_sts);                              // R10
    AST_CLAIM_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (done && outcome != 3'd5) |->
        (slot >= CNT_W'(2) && slot <= CNT_W'(ABORT_CLK - 1)));        // R3
endmodule

bind pci_term_ctl pti_term_checker #(.ABORT_CLK(ABORT_CLK), .CNT_W(CNT_W)) u_pti_chk (
    .clk(clk), .rst(rst), .frame_n(frame_n_o), .irdy_n(irdy_n_o),
    .busy(busy_o), .done(done_o), .outcome(outcome_o), .slot(claim_slot_o),
    .ma_pulse(mabort_pulse_o), .ma_sts(mabort_sts_o), .ta_sts(tabort_sts_o),
    .clr(sts_clr_i)
);

// File: tb/pci_term_ctl_bench.sv
module pci_term_ctl_bench;
    localparam int LEN_W = 8;
    localparam int CNT_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [LEN_W-1:0] len_i = '0;
    logic devsel_n_i = 1'b1, trdy_n_i = 1'b1, stop_n_i = 1'b1;
    logic [1:0] sts_clr_i = 2'b00;
    logic frame_n_o, irdy_n_o, busy_o, done_o, mabort_sts_o, tabort_sts_o, mabort_pulse_o;
    logic [2:0] outcome_o;
    logic [LEN_W-1:0] words_o;
    logic [CNT_W-1:0] claim_slot_o;

    always #2 clk = ~clk;

    pci_term_ctl u_pci_term_ctl (
        .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i),
        .devsel_n_i(devsel_n_i), .trdy_n_i(trdy_n_i), .stop_n_i(stop_n_i),
        .sts_clr_i(sts_clr_i), .frame_n_o(frame_n_o), .irdy_n_o(irdy_n_o),
        .busy_o(busy_o), .done_o(done_o), .outcome_o(outcome_o),
        .words_o(words_o), .claim_slot_o(claim_slot_o),
        .mabort_sts_o(mabort_sts_o), .tabort_sts_o(tabort_sts_o),
        .mabort_pulse_o(mabort_pulse_o)
    );

    int tests = 0, fails = 0;
    int frame_rel, irdy_rel, done_edge, pulses, got_words, got_out, got_slot;
    int e0_frame, e0_irdy, done_cycles;

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Launches one transaction and plays a zero-wait target claiming at
    // edge 'slot' (0 = nobody). At 'stop_edge' the target ends it:
    // kind 1 STOP+TRDY+DEVSEL, 2 STOP+DEVSEL only, 3 STOP with DEVSEL high.
    task automatic run_txn(input int len, input int slot, input int stop_edge,
                           input int kind, input int busy_start);
        bit finished = 0;
        frame_rel = 0; irdy_rel = 0; done_edge = 0; pulses = 0; done_cycles = 0;
        got_words = -1; got_out = -1; got_slot = -1;
        @(negedge clk);
        start_i = 1'b1; len_i = LEN_W'(len);
        @(posedge clk); #1;
        start_i = 1'b0;
        e0_frame = int'(frame_n_o); e0_irdy = int'(irdy_n_o);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1;
            if (!finished) begin
                if (slot != 0 && k >= slot) begin
                    devsel_n_i = 1'b0; trdy_n_i = 1'b0;
                end
                if (k == stop_edge) begin
                    stop_n_i = 1'b0;
                    if (kind == 2) trdy_n_i = 1'b1;
                    if (kind == 3) begin devsel_n_i = 1'b1; trdy_n_i = 1'b1; end
                end
            end
            start_i = (k == busy_start);
            @(posedge clk); #1;
            start_i = 1'b0;
            if (frame_n_o && frame_rel == 0) frame_rel = k;
            if (irdy_n_o && irdy_rel == 0) irdy_rel = k;
            if (mabort_pulse_o) pulses++;
            if (done_o) done_cycles++;
            if (done_o && done_edge == 0) begin
                done_edge = k; got_words = int'(words_o);
                got_out = int'(outcome_o); got_slot = int'(claim_slot_o);
                finished = 1;
            end
        end
        devsel_n_i = 1'b1; trdy_n_i = 1'b1; stop_n_i = 1'b1;
    endtask

    task automatic expect_end(input string req, input int fr, input int ir, input int de,
                              input int out, input int words);
        chk(req, "frame release edge", frame_rel, fr);
        chk(req, "irdy release edge", irdy_rel, ir);
        chk(req, "done edge", done_edge, de);
        chk(req, "outcome", got_out, out);
        chk(req, "words", got_words, words);
        chk("R12", "done pulse count", done_cycles, 1);
    endtask

    task automatic t_reset;
        chk("R1", "frame_n", int'(frame_n_o), 1);
        chk("R1", "irdy_n", int'(irdy_n_o), 1);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "sticky flags", int'({mabort_sts_o, tabort_sts_o, mabort_pulse_o}), 0);
        chk("R1", "outcome", int'(outcome_o), 0);
    endtask

    task automatic t_normal_fast;
        run_txn(3, 2, 0, 0, 0);
        chk("R2", "frame after start", e0_frame, 0);
        chk("R2", "irdy after start", e0_irdy, 1);
        expect_end("R7", 3, 4, 4, 0, 3);
        chk("R3", "fast slot", got_slot, 2);
        chk("R12", "busy after done", int'(busy_o), 0);
    endtask

    task automatic t_claim_slots;
        run_txn(1, 3, 0, 0, 0);            // medium, single word
        expect_end("R7", 1, 3, 3, 0, 1);
        chk("R3", "medium slot", got_slot, 3);
        run_txn(2, 4, 0, 0, 0);            // slow
        expect_end("R7", 4, 5, 5, 0, 2);
        chk("R3", "slow slot", got_slot, 4);
        run_txn(2, 5, 0, 0, 0);            // subtractive, last slot before abort
        expect_end("R3", 5, 6, 6, 0, 2);
        chk("R3", "subtractive slot", got_slot, 5);
        chk("R5", "no abort pulse on late claim", pulses, 0);
        chk("R5", "no abort flag on late claim", int'(mabort_sts_o), 0);
    endtask

    task automatic t_master_abort;
        run_txn(4, 0, 0, 0, 0);
        expect_end("R4", 5, 6, 6, 5, 0);
        chk("R5", "abort pulses", pulses, 1);
        chk("R5", "abort flag", int'(mabort_sts_o), 1);
        run_txn(1, 0, 0, 0, 0);            // FRAME# already high
        expect_end("R4", 1, 6, 6, 5, 0);
    endtask

    task automatic t_sticky_clear;
        run_txn(3, 2, 0, 0, 0);
        chk("R6", "flag survives later good cycle", int'(mabort_sts_o), 1);
        @(negedge clk); sts_clr_i = 2'b10;
        @(posedge clk); #1; sts_clr_i = 2'b00;
        chk("R6", "other strobe leaves flag", int'(mabort_sts_o), 1);
        @(negedge clk); sts_clr_i = 2'b01;
        @(posedge clk); #1; sts_clr_i = 2'b00;
        chk("R6", "flag cleared", int'(mabort_sts_o), 0);
    endtask

    task automatic t_target_ends;
        run_txn(4, 2, 3, 1, 0);
        expect_end("R8", 3, 4, 4, 1, 2);
        run_txn(4, 2, 2, 2, 0);
        expect_end("R9", 2, 3, 3, 3, 0);
        run_txn(4, 2, 3, 2, 0);
        expect_end("R9", 3, 4, 4, 2, 1);
        run_txn(2, 2, 3, 1, 0);            // stop on final phase, FRAME# high
        expect_end("R11", 2, 3, 3, 1, 2);
        chk("R10", "target abort flag before", int'(tabort_sts_o), 0);
        run_txn(4, 2, 3, 3, 0);
        expect_end("R10", 3, 4, 4, 4, 1);
        chk("R10", "target abort flag", int'(tabort_sts_o), 1);
        chk("R10", "master flag untouched", int'(mabort_sts_o), 0);
        @(negedge clk); sts_clr_i = 2'b10;
        @(posedge clk); #1; sts_clr_i = 2'b00;
        chk("R6", "target flag cleared", int'(tabort_sts_o), 0);
    endtask

    task automatic t_busy_start;
        run_txn(3, 2, 0, 0, 2);
        expect_end("R2", 3, 4, 4, 0, 3);
        chk("R2", "idle after ignored start", int'(busy_o), 0);
        chk("R2", "frame idle after ignored start", int'(frame_n_o), 1);
    endtask

    bit finished_all = 0;
    initial begin
        #(4 * 100000);
        if (!finished_all) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_normal_fast;
        t_claim_slots;
        t_master_abort;
        t_sticky_clear;
        t_target_ends;
        t_busy_start;
        finished_all = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule